// File: doc/BRIEF.md
# Two-Wire Switch-Control Register Slave

This block is a slave on a two-wire I2C-compatible bus. It holds one 8-bit word, and each bit of that word turns one analog switch on or off. A bus master addresses the block and writes new switch words or reads the current word back. Each data byte the master writes takes effect as soon as the block has acknowledged it. The master can send several bytes after one address byte, and each of those bytes changes the switches again.

The serial clock and data lines are sampled by the system clock. Each line passes through a two-flop synchronizer and a run-length glitch filter before any bus event is decoded. The block pulls the data line low through an open-drain enable output. Two strap inputs set the low two bits of the slave address. A parameter sets the upper five bits, so two variants of the block can share a bus. Each variant can appear up to four times on the bus.

Top module: `swreg_i2c_slave`

## Requirements
- R1: While `rstN` is low and right after it is released, `switchWord` is 0, `updateStb` is 0 and `sdaDrvLow` is 0.
- R2: The first byte after a START is received MSB first. It is {ADDR_PREFIX (5 bits), addrStrap[1], addrStrap[0], R/W}, where R/W = 1 means read. When bits 7..1 match, the block drives `sdaDrvLow` high for the ninth clock pulse (ACK).
- R3: When the address does not match, the block does not acknowledge. It ignores all following bus traffic until the next START, so `switchWord` does not change.
- R4: In a write, each data byte is received MSB first and bit i lands in `switchWord[i]`. Each byte is acknowledged. At the falling SCL edge that ends the ACK pulse, the byte is committed and `updateStb` pulses for exactly one clock. Any number of bytes may follow one address byte.
- R5: `switchWord` changes only in a cycle where `updateStb` is high, and `updateStb` is never high for two cycles in a row.
- R6: In a read, the block returns `switchWord` MSB first. A master ACK (SDA low on the ninth pulse) causes the same register to be sent again. A master NACK ends the transfer.
- R7: `sdaDrvLow` changes only while SCL is low. It is released after each ACK pulse and after the eighth bit of a read byte.
- R8: A START received in the middle of a byte abandons that byte without committing it, and a new address phase begins.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system-clock samples (2 cycles with the default of 3) has no effect.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Bits clocked in after it without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset; clears the switch word |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sdaDrvLow | output | 1 | 1 pulls SDA low through the open-drain pad |
| addrStrap | input | STRAP_W | Address straps: bit 1 is address bit 1, bit 0 is address bit 0 |
| switchWord | output | BYTE_W | Switch enables; bit i closes switch i+1 |
| updateStb | output | 1 | One-clock pulse when a new switch word is committed |

## Verification
Some properties hold on every cycle, and the checker asserts them continuously. The data-line enable only toggles while the filtered clock is low. The strobe lasts a single cycle. The switch word never moves without the strobe. SDA is released whenever a commit happens. Reset clears the word. The bench scenarios cover what depends on whole bus transactions: address matching against both the strap pins and the prefix, bit ordering, multi-byte writes, reads repeated under master ACK, abort by a START in the middle of a byte, and rejection of short glitches on both lines.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
    logic commit;
    logic oeAck;
    logic oeTx;
    logic oeRelease;
  } dpCtl_t;

endpackage

// File: rtl/swreg_filter.sv
module swreg_filter #(
  parameter int LINES    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] runCnt;
    logic             level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= 2'b11;
        runCnt <= '0;
        level  <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] == level) begin
          runCnt <= '0;
        end else if (runCnt == CNT_LAST) begin
          level  <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end

    assign cleanOut[g] = level;
  end
endmodule

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclF,
  input  logic   sdaF,
  input  logic   cntFull,
  input  logic   addrHit,
  input  logic   rwBit,
  output dpCtl_t ctl
);
  busState_t state, stateNext;
  logic sclPrev, sdaPrev;
  logic mAck, mAckNext;
  logic startDet, stopDet, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      mAck    <= 1'b0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      state   <= stateNext;
      mAck    <= mAckNext;
    end
  end

  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;

  always_comb begin
    stateNext = state;
    mAckNext  = mAck;
    ctl       = '0;
    if (startDet) begin
      stateNext     = ST_ADDR;
      ctl.clrCnt    = 1'b1;
      ctl.oeRelease = 1'b1;
    end else if (stopDet) begin
      stateNext     = ST_IDLE;
      ctl.clrCnt    = 1'b1;
      ctl.oeRelease = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise) begin
            ctl.shiftRx = 1'b1;
          end else if (sclFall && cntFull) begin
            if (addrHit) begin
              ctl.oeAck = 1'b1;
              stateNext = ST_ADDR_ACK;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (rwBit) begin
              ctl.loadTx = 1'b1;
              ctl.oeTx   = 1'b1;
              stateNext  = ST_RD_DATA;
            end else begin
              ctl.oeRelease = 1'b1;
              stateNext     = ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: begin
          if (sclRise) begin
            ctl.shiftRx = 1'b1;
          end else if (sclFall && cntFull) begin
            ctl.oeAck = 1'b1;
            stateNext = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ctl.oeRelease = 1'b1;
            ctl.commit    = 1'b1;
            ctl.clrCnt    = 1'b1;
            stateNext     = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (sclRise) begin
            ctl.shiftRx = 1'b1;
          end else if (sclFall) begin
            if (cntFull) begin
              ctl.oeRelease = 1'b1;
              stateNext     = ST_RD_ACK;
            end else begin
              ctl.shiftTx = 1'b1;
              ctl.oeTx    = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mAckNext = ~sdaF;
          end else if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (mAck) begin
              ctl.loadTx = 1'b1;
              ctl.oeTx   = 1'b1;
              stateNext  = ST_RD_DATA;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swreg_dp.sv
module swreg_dp
  import swreg_pkg::*;
#(
  parameter int PREFIX_W = 5,
  parameter int STRAP_W  = 2,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10011,
  localparam int BYTE_W  = PREFIX_W + STRAP_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaF,
  input  logic [STRAP_W-1:0] addrStrap,
  input  dpCtl_t             ctl,
  output logic               cntFull,
  output logic               addrHit,
  output logic               rwBit,
  output logic [BYTE_W-1:0]  switchWord,
  output logic               updateStb,
  output logic               sdaDrvLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift, txNext;

  assign cntFull = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit = (rxShift[BYTE_W-1:1] == {ADDR_PREFIX, addrStrap});
  assign rwBit   = rxShift[0];

  always_comb begin
    txNext = txShift;
    if (ctl.loadTx)       txNext = switchWord;
    else if (ctl.shiftTx) txNext = {txShift[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      rxShift    <= '0;
      txShift    <= '0;
      switchWord <= '0;
      updateStb  <= 1'b0;
      sdaDrvLow  <= 1'b0;
    end else begin
      if (ctl.clrCnt)                  bitCnt <= '0;
      else if (ctl.shiftRx && !cntFull) bitCnt <= bitCnt + 1'b1;
      if (ctl.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaF};
      txShift <= txNext;
      if (ctl.commit) switchWord <= rxShift;
      updateStb <= ctl.commit;
      if (ctl.oeRelease)  sdaDrvLow <= 1'b0;
      else if (ctl.oeAck) sdaDrvLow <= 1'b1;
      else if (ctl.oeTx)  sdaDrvLow <= ~txNext[BYTE_W-1];
    end
  end
endmodule

// File: rtl/swreg_i2c_slave.sv
module swreg_i2c_slave
  import swreg_pkg::*;
#(
  parameter int PREFIX_W = 5,
  parameter int STRAP_W  = 2,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10011,
  parameter int FILT_LEN = 3,
  localparam int BYTE_W  = PREFIX_W + STRAP_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDrvLow,
  input  logic [STRAP_W-1:0] addrStrap,
  output logic [BYTE_W-1:0]  switchWord,
  output logic               updateStb
);
  logic   sclFilt, sdaFilt;
  logic   cntFull, addrHit, rwBit;
  dpCtl_t ctl;

  swreg_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rstN(rstN),
    .rawIn({sclIn, sdaIn}),
    .cleanOut({sclFilt, sdaFilt})
  );

  swreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclFilt), .sdaF(sdaFilt),
    .cntFull(cntFull), .addrHit(addrHit), .rwBit(rwBit), .ctl(ctl)
  );

  swreg_dp #(.PREFIX_W(PREFIX_W), .STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(sdaFilt), .addrStrap(addrStrap), .ctl(ctl),
    .cntFull(cntFull), .addrHit(addrHit), .rwBit(rwBit),
    .switchWord(switchWord), .updateStb(updateStb), .sdaDrvLow(sdaDrvLow)
  );
endmodule

// File: rtl/swreg_chk.sv
module swreg_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclF,
  input logic              sdaDrvLow,
  input logic              updateStb,
  input logic [BYTE_W-1:0] switchWord
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> (switchWord == '0 && !sdaDrvLow));

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rstN) updateStb |=> !updateStb);

  // R5
  word_with_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(switchWord) |-> updateStb);

  // R7
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclF);

  // R7
  commit_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |-> !sdaDrvLow);
endmodule

bind swreg_i2c_slave swreg_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclFilt), .sdaDrvLow(sdaDrvLow),
  .updateStb(updateStb), .switchWord(switchWord)
);

// File: tb/swreg_i2c_slave_tb.sv
module swreg_i2c_slave_tb;
  localparam int Q = 8;
  localparam logic [7:0] ADDR_WR = 8'h9C;  // 10011,1,0,W
  localparam logic [7:0] ADDR_RD = 8'h9D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaDrvLow, updateStb;
  logic [7:0] switchWord;
  wire  sdaBus = sdaM & ~sdaDrvLow;

  int total = 0, bad = 0;
  int stbCount = 0, stbWide = 0, wordNoStb = 0, badEdge = 0;
  logic prevDrv = 1'b0, prevStb = 1'b0;
  logic [7:0] prevWord = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  swreg_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDrvLow(sdaDrvLow), .addrStrap(strap),
    .switchWord(switchWord), .updateStb(updateStb)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (updateStb) stbCount++;
      if (updateStb && prevStb) stbWide++;
      if (switchWord != prevWord && !updateStb) wordNoStb++;
      if (sdaDrvLow != prevDrv && sclM) badEdge++;
    end
    prevStb  = updateStb;
    prevWord = switchWord;
    prevDrv  = sdaDrvLow;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(2 * Q);
  endtask

  task automatic sendBits(logic [7:0] data, int n, bit sclGlitch);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = data[i]; waitClk(Q);
      sclM = 1'b1; waitClk(Q);
      if (sclGlitch) begin
        sclM = 1'b0; waitClk(2);
        sclM = 1'b1; waitClk(Q - 2);
      end else begin
        waitClk(Q);
      end
      sclM = 1'b0; waitClk(Q);
    end
  endtask

  task automatic sendByte(logic [7:0] data, output bit ack, input bit sclGlitch = 1'b0);
    sendBits(data, 8, sclGlitch);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    ack = ~sdaBus;
    waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic readByte(bit giveAck, output logic [7:0] data);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      sclM = 1'b1; waitClk(Q);
      data[i] = sdaBus;
      waitClk(Q);
      sclM = 1'b0; waitClk(Q);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(2 * Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic testReset();
    chk("R1 word", switchWord, 8'h00);
    chk("R1 strobe", updateStb, 1'b0);
    chk("R1 sda", sdaDrvLow, 1'b0);
  endtask

  task automatic testSingleWrite();
    bit a0, a1;
    int s0 = stbCount;
    startCond();
    sendByte(ADDR_WR, a0);
    sendByte(8'hA5, a1);
    stopCond();
    chk("R2 address ack", a0, 1'b1);
    chk("R4 data ack", a1, 1'b1);
    chk("R4 word", switchWord, 8'hA5);
    chk("R4 strobe count", stbCount - s0, 1);
    chk("R10 sda released", sdaDrvLow, 1'b0);
  endtask

  task automatic testBurstWrite();
    bit a;
    int s0 = stbCount;
    startCond();
    sendByte(ADDR_WR, a);
    sendByte(8'h01, a);
    chk("R4 burst byte1 lsb", switchWord, 8'h01);
    sendByte(8'h80, a);
    chk("R4 burst byte2 msb", switchWord, 8'h80);
    sendByte(8'h3C, a);
    stopCond();
    chk("R4 burst final", switchWord, 8'h3C);
    chk("R4 burst strobes", stbCount - s0, 3);
  endtask

  task automatic testNoMatch();
    bit a0, a1;
    int s0 = stbCount;
    startCond();
    sendByte(8'h9A, a0);  // strap bits 01
    sendByte(8'hFF, a1);
    stopCond();
    chk("R3 wrong strap no ack", a0, 1'b0);
    chk("R3 data ignored ack", a1, 1'b0);
    startCond();
    sendByte(8'h8C, a0);  // other prefix 10001
    sendByte(8'h00, a1);
    stopCond();
    chk("R3 wrong prefix no ack", a0, 1'b0);
    chk("R3 word unchanged", switchWord, 8'h3C);
    chk("R3 no strobe", stbCount - s0, 0);
  endtask

  task automatic testRead();
    bit a;
    logic [7:0] d0, d1;
    startCond();
    sendByte(ADDR_WR, a);
    sendByte(8'h5A, a);
    startCond();
    sendByte(ADDR_RD, a);
    chk("R2 read address ack", a, 1'b1);
    readByte(1'b1, d0);
    readByte(1'b0, d1);
    chk("R7 released after nack", sdaDrvLow, 1'b0);
    stopCond();
    chk("R6 first read", d0, 8'h5A);
    chk("R6 repeated read", d1, 8'h5A);
  endtask

  task automatic testAbort();
    bit a;
    int s0 = stbCount;
    startCond();
    sendByte(ADDR_WR, a);
    sendBits(8'hF0, 4, 1'b0);
    startCond();
    sendByte(ADDR_WR, a);
    chk("R8 new address acked", a, 1'b1);
    sendByte(8'hC3, a);
    stopCond();
    chk("R8 word", switchWord, 8'hC3);
    chk("R8 strobes", stbCount - s0, 1);
  endtask

  task automatic testGlitch();
    bit a;
    int s0;
    startCond();
    sendByte(ADDR_WR, a);
    sendByte(8'h96, a, 1'b1);
    stopCond();
    chk("R9 scl glitch rejected", switchWord, 8'h96);
    s0 = stbCount;
    // short SDA low pulse while SCL high must not act as START
    sdaM = 1'b0; waitClk(2);
    sdaM = 1'b1; waitClk(2 * Q);
    sclM = 1'b0; waitClk(Q);
    sendByte(ADDR_WR, a);
    sendByte(8'h11, a);
    stopCond();
    chk("R9 sda glitch no ack", a, 1'b0);
    chk("R10 bits after stop ignored", switchWord, 8'h96);
    chk("R9 no strobe", stbCount - s0, 0);
  endtask

  task automatic testMonitors();
    chk("R5 strobe one cycle", stbWide, 0);
    chk("R5 word only with strobe", wordNoStb, 0);
    chk("R7 sda edges in scl low", badEdge, 0);
  endtask

  task automatic testResetMid();
    rstN = 1'b0; waitClk(3);
    chk("R1 word in reset", switchWord, 8'h00);
    rstN = 1'b1; waitClk(3);
    chk("R1 word after reset", switchWord, 8'h00);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(10);
    testReset();
    testSingleWrite();
    testBurstWrite();
    testNoMatch();
    testRead();
    testAbort();
    testGlitch();
    testMonitors();
    testResetMid();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end
endmodule